// File: doc/BRIEF.md
# Program Counter and Return Stack

This block sequences instruction fetch for a small 8-bit microcontroller with a 10-bit program space. It holds the program counter, which names the instruction word fetched in the current cycle, and chooses the next value every cycle. The choices are a plain increment, a skip over one instruction, a jump inside the current 256-word page made by writing only the low address byte, an absolute jump or call, an interrupt vector, and a return. A two-slot hardware return stack saves return addresses for calls and interrupt entries. The interrupt controller reads its full flag and withholds acknowledgement while it is set.

The decoder drives one-cycle strobes for the instruction now executing. Every transfer of control raises a flush flag for the next cycle, which marks that cycle's fetched word as a dummy. The block ignores all strobes in that dummy cycle and only increments. A separate combinational path forms table-read addresses. These come either from the current page or from the fixed last page, with the low byte always taken from a table pointer.

Top module: `pc_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, the fetch address is 0x000, flush is low and the stack is empty (stack-full low).
- R2: With no strobe active, the fetch address grows by 1 each cycle and wraps from 0x3FF to 0x000.
- R3: A skip strobe makes the next fetch address the current one plus 2.
- R4: A low-byte write makes the next fetch address {current bits 9:8, written byte}.
- R5: A jump or call strobe loads all 10 bits of the target operand into the fetch address.
- R6: A call pushes the current fetch address plus 1, and a return loads the fetch address from the top slot and pops it, last in first out.
- R7: An interrupt acknowledge loads 0x004 when the source select is 0 (external) or 0x008 when it is 1 (timer), and pushes the current fetch address.
- R8: Stack-full is high exactly when 2 addresses are held. A push while full keeps the two most recent addresses, drops the oldest, and leaves stack-full high.
- R9: A return on an empty stack loads the top slot's stale content, and the stack stays empty. A pop moves each slot up by one and leaves the bottom slot unchanged.
- R10: Any transfer (skip, low-byte write, jump, call, return, interrupt) raises flush for exactly the next cycle. In that cycle every strobe is ignored and the fetch address increments by 1.
- R11: When several strobes coincide, the winner is: interrupt acknowledge, then return, then call, then jump, then low-byte write, then skip. The losers have no effect.
- R12: The table address is {2'b11, pointer} when the last-page select is 1, and {current fetch bits 9:8, pointer} when it is 0. It follows its inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| skip_i | input | 1 | Skip the next instruction |
| pcl_wr_i | input | 1 | Write the low address byte |
| pcl_data_i | input | 8 | Byte written to the low address byte |
| jump_i | input | 1 | Absolute jump |
| call_i | input | 1 | Subroutine call |
| target_i | input | 10 | Jump or call target |
| ret_i | input | 1 | Return (from subroutine or interrupt) |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| irq_src_i | input | 1 | Interrupt source: 0 external, 1 timer |
| tbl_ptr_i | input | 8 | Table pointer byte |
| tbl_last_i | input | 1 | Table read from the last page |
| fetch_addr_o | output | 10 | Program memory fetch address |
| tbl_addr_o | output | 10 | Table-read address |
| flush_o | output | 1 | Current fetched word is a dummy |
| stack_full_o | output | 1 | Two return addresses held |

## Verification
Two functions can land in the same cycle. One is a stack push from a call or an interrupt acknowledge. The other is a transfer strobe arriving in a dummy cycle, which must be ignored, or a push arriving while the stack is already full. The bench sweeps every combination of the six strobes across many cycles, so strobes often arrive in flush cycles and calls often arrive on a full stack. A model of the priority order, the flush rule and the shifting two-slot stack judges each cycle by comparing fetch address, flush and stack-full. Directed call and return runs then check that the oldest address is the one dropped and that a return on an empty stack does not disturb later pushes.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
   typedef enum logic [2:0] {
      SRC_INC,
      SRC_SKIP,
      SRC_PAGE,
      SRC_ABS,
      SRC_RET,
      SRC_VEC
   } pc_src_e;
endpackage

// File: rtl/pcseq_ctrl.sv
module pcseq_ctrl
   import pcseq_pkg::*;
(
   input  logic    dummy_i,
   input  logic    irq_ack_i,
   input  logic    ret_i,
   input  logic    call_i,
   input  logic    jump_i,
   input  logic    pcl_wr_i,
   input  logic    skip_i,
   output pc_src_e src_o,
   output logic    push_o,
   output logic    push_inc_o,
   output logic    pop_o,
   output logic    xfer_o
);
   // R11 priority, R10 dummy-cycle gating
   always_comb begin
      src_o      = SRC_INC;
      push_o     = 1'b0;
      push_inc_o = 1'b0;
      pop_o      = 1'b0;
      if (!dummy_i) begin
         if (irq_ack_i) begin
            src_o  = SRC_VEC;
            push_o = 1'b1;
         end else if (ret_i) begin
            src_o = SRC_RET;
            pop_o = 1'b1;
         end else if (call_i) begin
            src_o      = SRC_ABS;
            push_o     = 1'b1;
            push_inc_o = 1'b1;
         end else if (jump_i) begin
            src_o = SRC_ABS;
         end else if (pcl_wr_i) begin
            src_o = SRC_PAGE;
         end else if (skip_i) begin
            src_o = SRC_SKIP;
         end
      end
      xfer_o = (src_o != SRC_INC);
   end

   always_comb begin
      assert_push_pop_excl_R6: assert (!(push_o && pop_o));
   end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
   parameter int W     = 10,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic         pop_i,
   input  logic [W-1:0] push_val_i,
   output logic [W-1:0] top_o,
   output logic         full_o
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [W-1:0]  slot [DEPTH];
   logic [CW-1:0] count_q;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("pcseq_stack: DEPTH must be at least 1");
      end
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot[g] <= '0;
            end else if (push_i) begin
               if (g == 0) slot[g] <= push_val_i;
               else        slot[g] <= slot[(g == 0) ? 0 : g - 1];
            end else if (pop_i) begin
               if (g < DEPTH - 1) slot[g] <= slot[(g < DEPTH - 1) ? g + 1 : g];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          count_q <= '0;
      else if (push_i && count_q != FULL_CNT) count_q <= count_q + 1'b1;
      else if (pop_i && count_q != '0)     count_q <= count_q - 1'b1;
   end

   assign top_o  = slot[0];
   assign full_o = (count_q == FULL_CNT);

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FULL_CNT);
   assert_full_push_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full_o) |=> full_o);
   assert_push_lands_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> top_o == $past(push_val_i));
   assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && count_q == '0) |=> count_q == '0);
endmodule

// File: rtl/pcseq_tbl_addr.sv
module pcseq_tbl_addr #(
   parameter int PC_W   = 10,
   parameter int PAGE_W = 8
) (
   input  logic [PC_W-PAGE_W-1:0] page_i,
   input  logic [PAGE_W-1:0]      ptr_i,
   input  logic                   last_i,
   output logic [PC_W-1:0]        addr_o
);
   always_comb begin
      addr_o = last_i ? {{(PC_W-PAGE_W){1'b1}}, ptr_i} : {page_i, ptr_i};
   end

   always_comb begin
      assert_tbl_low_byte_R12: assert (addr_o[PAGE_W-1:0] == ptr_i);
   end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
   import pcseq_pkg::*;
#(
   parameter int PC_W      = 10,
   parameter int PAGE_W    = 8,
   parameter int STK_DEPTH = 2,
   parameter int VEC_EXT   = 4,
   parameter int VEC_TMR   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            skip_i,
   input  logic            pcl_wr_i,
   input  logic [PAGE_W-1:0] pcl_data_i,
   input  logic            jump_i,
   input  logic            call_i,
   input  logic [PC_W-1:0] target_i,
   input  logic            ret_i,
   input  logic            irq_ack_i,
   input  logic            irq_src_i,
   input  logic [PAGE_W-1:0] tbl_ptr_i,
   input  logic            tbl_last_i,
   output logic [PC_W-1:0] fetch_addr_o,
   output logic [PC_W-1:0] tbl_addr_o,
   output logic            flush_o,
   output logic            stack_full_o
);
   localparam int HI_W = PC_W - PAGE_W;
   localparam logic [PC_W-1:0] VEXT = PC_W'(VEC_EXT);
   localparam logic [PC_W-1:0] VTMR = PC_W'(VEC_TMR);

   generate
      if (PC_W <= PAGE_W) begin : g_bad_width
         $error("pc_sequencer: PC_W must exceed PAGE_W");
      end
   endgenerate

   logic [PC_W-1:0] pc_q, pc_d, push_val, stk_top;
   logic            dummy_q;
   pc_src_e         src;
   logic            push, push_inc, pop, xfer;

   pcseq_ctrl ctrl_i (
      .dummy_i   (dummy_q),
      .irq_ack_i (irq_ack_i),
      .ret_i     (ret_i),
      .call_i    (call_i),
      .jump_i    (jump_i),
      .pcl_wr_i  (pcl_wr_i),
      .skip_i    (skip_i),
      .src_o     (src),
      .push_o    (push),
      .push_inc_o(push_inc),
      .pop_o     (pop),
      .xfer_o    (xfer)
   );

   assign push_val = push_inc ? pc_q + 1'b1 : pc_q;

   pcseq_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) stack_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_i    (push),
      .pop_i     (pop),
      .push_val_i(push_val),
      .top_o     (stk_top),
      .full_o    (stack_full_o)
   );

   always_comb begin
      unique case (src)
         SRC_SKIP: pc_d = pc_q + PC_W'(2);
         SRC_PAGE: pc_d = {pc_q[PC_W-1:PAGE_W], pcl_data_i};
         SRC_ABS:  pc_d = target_i;
         SRC_RET:  pc_d = stk_top;
         SRC_VEC:  pc_d = irq_src_i ? VTMR : VEXT;
         default:  pc_d = pc_q + 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         dummy_q <= 1'b0;
      end else begin
         pc_q    <= pc_d;
         dummy_q <= xfer;
      end
   end

   pcseq_tbl_addr #(.PC_W(PC_W), .PAGE_W(PAGE_W)) tbl_i (
      .page_i (pc_q[PC_W-1:PAGE_W]),
      .ptr_i  (tbl_ptr_i),
      .last_i (tbl_last_i),
      .addr_o (tbl_addr_o)
   );

   assign fetch_addr_o = pc_q;
   assign flush_o      = dummy_q;

   assert_dummy_increments_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> (fetch_addr_o == $past(fetch_addr_o) + 1'b1) && !flush_o);
   assert_jump_flushes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (jump_i && !flush_o) |=> flush_o);
   assert_skip_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (skip_i && !flush_o && !irq_ack_i && !ret_i && !call_i && !jump_i && !pcl_wr_i)
      |=> fetch_addr_o == $past(fetch_addr_o) + PC_W'(2));
   assert_page_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pcl_wr_i && !flush_o && !irq_ack_i && !ret_i && !call_i && !jump_i)
      |=> fetch_addr_o == {$past(fetch_addr_o[PC_W-1:PAGE_W]), $past(pcl_data_i)});
   assert_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack_i && !flush_o) |=> (fetch_addr_o == VEXT || fetch_addr_o == VTMR));
   assert_idle_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_o && !irq_ack_i && !ret_i && !call_i && !jump_i && !pcl_wr_i && !skip_i)
      |=> fetch_addr_o == $past(fetch_addr_o) + 1'b1);
endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       skip_i = 0, pcl_wr_i = 0, jump_i = 0, call_i = 0, ret_i = 0;
   logic       irq_ack_i = 0, irq_src_i = 0, tbl_last_i = 0;
   logic [7:0] pcl_data_i = '0, tbl_ptr_i = '0;
   logic [9:0] target_i = '0;
   logic [9:0] fetch_addr_o, tbl_addr_o;
   logic       flush_o, stack_full_o;

   int checks = 0;
   int failures = 0;

   // model state
   logic [9:0] m_pc = '0;
   logic [9:0] m_stk [2];
   int         m_cnt = 0;
   logic       m_flush = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #10 clk = ~clk;

   pc_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .skip_i(skip_i), .pcl_wr_i(pcl_wr_i),
      .pcl_data_i(pcl_data_i), .jump_i(jump_i), .call_i(call_i),
      .target_i(target_i), .ret_i(ret_i), .irq_ack_i(irq_ack_i),
      .irq_src_i(irq_src_i), .tbl_ptr_i(tbl_ptr_i), .tbl_last_i(tbl_last_i),
      .fetch_addr_o(fetch_addr_o), .tbl_addr_o(tbl_addr_o),
      .flush_o(flush_o), .stack_full_o(stack_full_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] nxt(input logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   task automatic m_push(input logic [9:0] v);
      m_stk[1] = m_stk[0];
      m_stk[0] = v;
      if (m_cnt < 2) m_cnt++;
   endtask

   task automatic m_pop();
      m_stk[0] = m_stk[1];
      if (m_cnt > 0) m_cnt--;
   endtask

   // strobes: {irq, ret, call, jump, pcl, skip}; inputs driven at negedge
   task automatic step(input logic [5:0] s, input logic [9:0] tgt,
                       input logic [7:0] dat, input logic src);
      string tag;
      int    nset;
      nset = $countones(s);
      {irq_ack_i, ret_i, call_i, jump_i, pcl_wr_i, skip_i} = s;
      target_i = tgt; pcl_data_i = dat; irq_src_i = src;
      if (m_flush) begin
         tag = "R10"; m_pc = m_pc + 10'd1; m_flush = 0;
      end else begin
         m_flush = (s != 0);
         if (s[5]) begin
            tag = "R7"; m_push(m_pc); m_pc = src ? 10'h008 : 10'h004;
         end else if (s[4]) begin
            tag = (m_cnt == 0) ? "R9" : "R6"; m_pc = m_stk[0]; m_pop();
         end else if (s[3]) begin
            tag = (m_cnt == 2) ? "R8" : "R6"; m_push(m_pc + 10'd1); m_pc = tgt;
         end else if (s[2]) begin
            tag = "R5"; m_pc = tgt;
         end else if (s[1]) begin
            tag = "R4"; m_pc = {m_pc[9:8], dat};
         end else if (s[0]) begin
            tag = "R3"; m_pc = m_pc + 10'd2;
         end else begin
            tag = "R2"; m_pc = m_pc + 10'd1;
         end
         if (nset > 1) tag = {tag, "/R11"};
      end
      @(negedge clk);
      chk(fetch_addr_o == m_pc, {tag, " fetch"}, fetch_addr_o, m_pc);
      chk(flush_o == m_flush, "R10 flush", flush_o, m_flush);
      chk(stack_full_o == (m_cnt == 2), "R8 stack_full", stack_full_o, m_cnt == 2);
      {irq_ack_i, ret_i, call_i, jump_i, pcl_wr_i, skip_i} = '0;
   endtask

   initial begin
      #(20 * 190000);
      failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      m_stk[0] = '0; m_stk[1] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(fetch_addr_o == 10'h000, "R1 fetch", fetch_addr_o, 0);
      chk(flush_o == 1'b0, "R1 flush", flush_o, 0);
      chk(stack_full_o == 1'b0, "R1 stack_full", stack_full_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      m_pc = 10'h001;
      chk(fetch_addr_o == 10'h001, "R1 first cycle", fetch_addr_o, 1);

      // R9: return on empty stack, then three calls (R8 drops oldest), returns
      step(6'b010000, '0, '0, 0); step(6'b000000, '0, '0, 0);
      step(6'b001000, 10'h111, '0, 0); step(6'b000000, '0, '0, 0);
      step(6'b001000, 10'h222, '0, 0); step(6'b000000, '0, '0, 0);
      step(6'b001000, 10'h333, '0, 0); step(6'b000000, '0, '0, 0);
      for (int k = 0; k < 3; k++) begin
         step(6'b010000, '0, '0, 0); step(6'b000000, '0, '0, 0);
      end

      // R7: both vectors
      step(6'b100000, '0, '0, 0); step(6'b000000, '0, '0, 0);
      step(6'b100000, '0, '0, 1); step(6'b000000, '0, '0, 0);
      step(6'b010000, '0, '0, 0); step(6'b010000, '0, '0, 0);

      // R2: wrap at top of space
      step(6'b000100, 10'h3FD, '0, 0);
      for (int k = 0; k < 5; k++) step(6'b000000, '0, '0, 0);

      // R12: table address sweep over pointer and page select
      for (int k = 0; k < 512; k++) begin
         tbl_ptr_i  = 8'(k);
         tbl_last_i = k[8];
         #1;
         chk(tbl_addr_o == (tbl_last_i ? {2'b11, tbl_ptr_i} : {m_pc[9:8], tbl_ptr_i}),
             "R12 table address", tbl_addr_o,
             tbl_last_i ? {2'b11, tbl_ptr_i} : {m_pc[9:8], tbl_ptr_i});
         step(6'b000000, '0, '0, 0);
         if (k % 97 == 5) begin
            step(6'b000100, {lfsr[9:8], 8'h00} ^ 10'h2A5, '0, 0);
            lfsr = nxt(lfsr);
         end
      end

      // R11/R10 sweep: every strobe combination, several times
      for (int r = 0; r < 6; r++) begin
         for (int c = 0; c < 64; c++) begin
            lfsr = nxt(lfsr);
            step(6'(c), lfsr[9:0], lfsr[15:8], lfsr[3]);
            if (lfsr[5]) step(6'(c ^ 6'h15), lfsr[12:3], lfsr[7:0], lfsr[0]);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule